// File: doc/BRIEF.md
# Majority-Vote Phase Step Controller

This block closes a first-order bang-bang loop around a receiver phase interpolator. Every 32 unit intervals an upstream phase detector delivers one group of eight early/late votes. The block counts the early and late votes and, when one side has a strict majority, moves the interpolator select code by exactly one position. The code has 64 positions per unit interval, so each step shifts the sampling point by 1/64 UI. There is no frequency accumulator. A frequency offset between the link ends is tracked only by repeated single steps. The highest rate is one step per group, about 488 ppm, which covers the ±200 ppm that two ±100 ppm clocks can produce.

Vote groups arrive on a valid/ready stream. The block accepts a group on any clock edge where `vote_valid` and `vote_ready` are both high. `vote_ready` is low during reset and stays high from the first edge after reset, so the block never back-pressures a running source. The source may hold `vote_valid` low for any number of cycles, and nothing changes while it does. A group that has been accepted cannot be withdrawn. The code wraps modulo 64, so the sampling phase can rotate without limit in either direction. A `settled` flag reports when the loop is only dithering about a fixed phase.

Top module: `pstep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `phase_code` loads `INIT_CODE` (default 0), and `step_up`, `step_dn`, `settled` and `vote_ready` go low. `vote_ready` is high from the first edge after `rst` falls.
- R2: Slot i of `votes` is bits [2i+1:2i]. The code 2'b01 is an early vote and 2'b10 is a late vote. The codes 2'b00 and 2'b11 are no-votes and are ignored.
- R3: When an accepted group has more late votes than early votes, `phase_code` increments by one at that edge, and `step_up` is high for the following cycle.
- R4: When an accepted group has more early votes than late votes, `phase_code` decrements by one at that edge, and `step_dn` is high for the following cycle.
- R5: When an accepted group has equal early and late counts, including a group with no votes at all, `phase_code` is held and no pulse is given.
- R6: The code wraps modulo 64: an increment from 63 gives 0, and a decrement from 0 gives 63.
- R7: Without an accepted group, `phase_code` is unchanged and both pulses are low in the next cycle. Each accepted group moves the code by at most one step.
- R8: `step_up` and `step_dn` are never high together. Each pulse lasts one cycle unless the next edge also accepts a stepping group.
- R9: `settled` rises at the edge that accepts the 16th consecutive calm group. A calm group is one with no step, or with a step whose direction differs from the last applied step.
- R10: `settled` falls at the edge that applies the 4th consecutive step in one direction. Groups without a step neither extend nor break that run. A same-direction step restarts the calm count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vote_valid | input | 1 | A vote group is offered |
| vote_ready | output | 1 | The block can take a group (high after reset) |
| votes | input | 16 | Eight 2-bit votes, slot i at bits [2i+1:2i] |
| phase_code | output | 6 | Interpolator select code, 1/64 UI per step |
| step_up | output | 1 | One-cycle pulse for an increment |
| step_dn | output | 1 | One-cycle pulse for a decrement |
| settled | output | 1 | Loop is dithering around a fixed phase |

## Verification
A miscounted vote or a wrong majority shows up in `phase_code` and in the step pulses in the cycle right after the accepting edge. Every group therefore checks the decision on its own. A wrong wrap shows at once at the 0/63 boundary. A wrong settle counter shows only at the 16th calm group or at the 4th same-direction step. For that reason the bench samples `settled` on both sides of each of those counts.

// File: rtl/pstep_pkg.sv
package pstep_pkg;
  typedef enum logic [1:0] {
    VOTE_NONE  = 2'b00,
    VOTE_EARLY = 2'b01,
    VOTE_LATE  = 2'b10,
    VOTE_BAD   = 2'b11
  } vote_t;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } dir_t;
endpackage

// File: rtl/vote_tally.sv
module vote_tally import pstep_pkg::*; #(
  parameter int NUM_VOTES = 8,
  localparam int CNT_W = $clog2(NUM_VOTES + 1)
) (
  input  logic [2*NUM_VOTES-1:0] votes,
  output logic [CNT_W-1:0]       early_cnt,
  output logic [CNT_W-1:0]       late_cnt
);
  logic [NUM_VOTES-1:0] is_early;
  logic [NUM_VOTES-1:0] is_late;

  // R2: per-slot decode; 00 and 11 count as nothing
  for (genvar i = 0; i < NUM_VOTES; i++) begin : g_slot
    vote_t v;
    assign v           = vote_t'(votes[2*i +: 2]);
    assign is_early[i] = (v == VOTE_EARLY);
    assign is_late[i]  = (v == VOTE_LATE);
  end

  always_comb begin
    early_cnt = '0;
    late_cnt  = '0;
    for (int i = 0; i < NUM_VOTES; i++) begin
      early_cnt = early_cnt + CNT_W'(is_early[i]);
      late_cnt  = late_cnt  + CNT_W'(is_late[i]);
    end
  end
endmodule

// File: rtl/phase_code_reg.sv
module phase_code_reg #(
  parameter int CNT_W   = 4,
  parameter int CODE_W  = 6,
  parameter logic [CODE_W-1:0] INIT_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp,
  input  logic [CNT_W-1:0]  early_cnt,
  input  logic [CNT_W-1:0]  late_cnt,
  output logic              take_up,
  output logic              take_dn,
  output logic [CODE_W-1:0] code_q,
  output logic              up_q,
  output logic              dn_q
);
  // R3/R4/R5: strict majority only
  assign take_up = grp && (late_cnt > early_cnt);
  assign take_dn = grp && (early_cnt > late_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= INIT_CODE;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      up_q <= take_up;
      dn_q <= take_dn;
      // R6: natural modulo-2^CODE_W wrap
      if (take_up)      code_q <= code_q + CODE_W'(1);
      else if (take_dn) code_q <= code_q - CODE_W'(1);
    end
  end

  assert_one_dir_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_q, dn_q}));
  assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
    up_q |-> code_q == $past(code_q) + CODE_W'(1));
  assert_dn_step_R4: assert property (@(posedge clk) disable iff (rst)
    dn_q |-> code_q == $past(code_q) - CODE_W'(1));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!up_q && !dn_q) |-> code_q == $past(code_q));
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !grp |=> (!up_q && !dn_q));
endmodule

// File: rtl/settle_monitor.sv
module settle_monitor import pstep_pkg::*; #(
  parameter int SETTLE_GROUPS = 16,
  parameter int RUN_LIMIT     = 4,
  localparam int CALM_W = $clog2(SETTLE_GROUPS + 1),
  localparam int RUN_W  = $clog2(RUN_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic grp,
  input  logic take_up,
  input  logic take_dn,
  output logic settled_q
);
  dir_t              last_dir;
  logic [RUN_W-1:0]  run_cnt, run_nxt;
  logic [CALM_W-1:0] calm_cnt, calm_nxt;
  logic              stepped, same_dir;

  always_comb begin
    stepped  = take_up || take_dn;
    same_dir = (take_up && last_dir == DIR_UP) || (take_dn && last_dir == DIR_DN);
    run_nxt  = run_cnt;
    if (stepped)
      run_nxt = same_dir ? ((run_cnt < RUN_W'(RUN_LIMIT)) ? run_cnt + RUN_W'(1) : run_cnt)
                         : RUN_W'(1);
    if (same_dir)
      calm_nxt = '0;
    else if (calm_cnt < CALM_W'(SETTLE_GROUPS))
      calm_nxt = calm_cnt + CALM_W'(1);
    else
      calm_nxt = calm_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_dir  <= DIR_NONE;
      run_cnt   <= '0;
      calm_cnt  <= '0;
      settled_q <= 1'b0;
    end else if (grp) begin
      if (take_up)      last_dir <= DIR_UP;
      else if (take_dn) last_dir <= DIR_DN;
      run_cnt  <= run_nxt;
      calm_cnt <= calm_nxt;
      // R10 wins over R9
      if (same_dir && run_nxt >= RUN_W'(RUN_LIMIT)) settled_q <= 1'b0;
      else if (calm_nxt >= CALM_W'(SETTLE_GROUPS))  settled_q <= 1'b1;
    end
  end

  assert_clear_run_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(settled_q) |-> $past(same_dir && grp));
  assert_set_calm_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(settled_q) |-> $past(grp && !same_dir));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !grp |=> $stable(settled_q));
endmodule

// File: rtl/pstep_ctrl.sv
module pstep_ctrl #(
  parameter int NUM_VOTES     = 8,
  parameter int CODE_W        = 6,
  parameter logic [CODE_W-1:0] INIT_CODE = '0,
  parameter int SETTLE_GROUPS = 16,
  parameter int RUN_LIMIT     = 4,
  localparam int CNT_W = $clog2(NUM_VOTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vote_valid,
  output logic                   vote_ready,
  input  logic [2*NUM_VOTES-1:0] votes,
  output logic [CODE_W-1:0]      phase_code,
  output logic                   step_up,
  output logic                   step_dn,
  output logic                   settled
);
  logic [CNT_W-1:0] early_cnt, late_cnt;
  logic             grp, take_up, take_dn;

  always_ff @(posedge clk) begin
    if (rst) vote_ready <= 1'b0;
    else     vote_ready <= 1'b1;
  end

  assign grp = vote_valid && vote_ready;

  vote_tally #(.NUM_VOTES(NUM_VOTES)) u_tally (
    .votes(votes), .early_cnt(early_cnt), .late_cnt(late_cnt));

  phase_code_reg #(.CNT_W(CNT_W), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_code (
    .clk(clk), .rst(rst), .grp(grp), .early_cnt(early_cnt), .late_cnt(late_cnt),
    .take_up(take_up), .take_dn(take_dn),
    .code_q(phase_code), .up_q(step_up), .dn_q(step_dn));

  settle_monitor #(.SETTLE_GROUPS(SETTLE_GROUPS), .RUN_LIMIT(RUN_LIMIT)) u_settle (
    .clk(clk), .rst(rst), .grp(grp), .take_up(take_up), .take_dn(take_dn),
    .settled_q(settled));

  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> vote_ready);
endmodule

// File: tb/sim_pstep_ctrl.sv
module sim_pstep_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vote_valid = 1'b0;
  logic       vote_ready;
  logic [15:0] votes = '0;
  logic [5:0] phase_code;
  logic       step_up, step_dn, settled;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pstep_ctrl u0 (.clk(clk), .rst(rst), .vote_valid(vote_valid), .vote_ready(vote_ready),
    .votes(votes), .phase_code(phase_code), .step_up(step_up), .step_dn(step_dn),
    .settled(settled));

  // votes: 01 early, 10 late, 00/11 none; step: +1 up, -1 down, 0 hold
  localparam int NV = 11;
  localparam logic [15:0] TV_VOTES [NV] = '{
    16'h5555, 16'hAAAA, 16'hAA95, 16'hAA55, 16'h0000, 16'hFFFF,
    16'h0002, 16'h0001, 16'hFA95, 16'h02A5, 16'h5556 };
  localparam int TV_STEP [NV] = '{ -1, 1, 1, 0, 0, 0, 1, -1, 0, 1, -1 };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; vote_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk); vote_valid = 1'b1; votes = v;
    @(posedge clk);
    @(negedge clk); vote_valid = 1'b0;
  endtask

  initial begin
    int exp_code;
    repeat (2) @(negedge clk);
    // R1: state during reset
    chk("R1 code in reset", phase_code, 0);
    chk("R1 ready in reset", vote_ready, 0);
    chk("R1 pulses in reset", step_up | step_dn, 0);
    chk("R1 settled in reset", settled, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", vote_ready, 1);

    // table walk: R2 R3 R4 R5 R6
    exp_code = 0;
    for (int i = 0; i < NV; i++) begin
      send(TV_VOTES[i]);
      exp_code = (exp_code + TV_STEP[i]) & 63;
      chk($sformatf("R3/R4/R5/R6 vector %0d code", i), phase_code, exp_code);
      chk($sformatf("R3 vector %0d up", i), step_up, TV_STEP[i] == 1);
      chk($sformatf("R4 vector %0d dn", i), step_dn, TV_STEP[i] == -1);
    end

    // R8: pulse lasts one cycle
    send(16'hAAAA);
    exp_code = (exp_code + 1) & 63;
    @(negedge clk);
    chk("R8 up pulse dropped", step_up, 0);
    chk("R8 dn stays low", step_dn, 0);

    // R7: idle cycles change nothing
    votes = 16'hAAAA;
    repeat (5) @(negedge clk);
    chk("R7 code held when idle", phase_code, exp_code);
    chk("R7 no pulse when idle", step_up | step_dn, 0);

    // R7: back-to-back groups, one step each
    @(negedge clk); vote_valid = 1'b1; votes = 16'h5555;
    @(posedge clk); @(negedge clk);
    chk("R7 first of pair", phase_code, (exp_code - 1) & 63);
    @(posedge clk); @(negedge clk); vote_valid = 1'b0;
    chk("R7 second of pair", phase_code, (exp_code - 2) & 63);
    chk("R8 dn held for stepping pair", step_dn, 1);

    // R9: settled after 16 calm groups
    do_reset();
    for (int i = 0; i < 15; i++) send(16'hAA55);
    chk("R9 not settled after 15", settled, 0);
    send(16'h0000);
    chk("R9 settled after 16", settled, 1);

    // R10: three same-direction steps keep it, the fourth clears
    for (int i = 0; i < 3; i++) send(16'hAAAA);
    chk("R10 still settled after 3 ups", settled, 1);
    send(16'h0000);
    chk("R10 no-step group keeps flag", settled, 1);
    send(16'hAAAA);
    chk("R10 cleared on 4th up", settled, 0);
    chk("R10 code after 4 ups", phase_code, 4);

    // R9: alternating steps count as calm
    for (int i = 0; i < 8; i++) begin
      send(16'h5555);
      if (i < 7) send(16'hAAAA);
    end
    chk("R9 not settled after 15 alternating", settled, 0);
    send(16'hAAAA);
    chk("R9 settled after 16 alternating", settled, 1);
    chk("R9 code back after alternation", phase_code, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule